// File: doc/BRIEF.md
# Pixel Packing Output Queue for a Display Panel

This block sits between a pixel pipeline and the data pins of a display panel. Pixels of any width from 1 to 16 bits arrive one per handshake and are appended to a packing shifter. Once the shifter holds enough bits for the selected panel width, it hands a chunk to two byte-wide, sixteen-entry queues. These queues work as fall-through shift registers: a read always takes the entry at the bottom, and everything above it moves down one place.

A two-bit panel-mode input sets three things: the chunk size (4, 8 or 16 bits), which queues receive data, and how many pins are driven. The read side pops on each pixel-clock strobe and drives the panel pins from a register. When a read finds no data, a sticky underflow flag is set and the pins keep their last value. A synchronous enable empties everything, and while the block is disabled the pins are held at zero.

Top module: `lcd_pack_fifo`

## Requirements
- R1: After reset, and in every cycle that follows a cycle with `enable` low, both queues are empty and not full, the shifter is empty, `pix_ready` is 0, `pins` is 0 and `underflow` is 0.
- R2: Pixel bits are gathered least-significant first. Each accepted pixel supplies its low `pix_bits` bits, where a `pix_bits` value of 0 means 16. These bits are placed directly above the bits already gathered, so the earliest gathered bit becomes bit 0 of the next chunk.
- R3: The chunk size follows `panel_mode`: 2'b00 gives 4 bits, 2'b01 gives 8 bits, and 2'b10 or 2'b11 give 16 bits. Bits beyond a chunk stay in the shifter and start the next chunk.
- R4: In mode 2'b01, each byte goes to queue 0 only, and queue 1 stays empty. A read pops one byte and drives it on `pins[7:0]`, with `pins[15:8]` at 0.
- R5: In 16-bit modes, the low byte of a chunk enters queue 0 and the high byte enters queue 1 in the same cycle. A read pops both queues and drives `pins` = {queue 1 byte, queue 0 byte}.
- R6: In mode 2'b00, two consecutive nibbles form one queue 0 byte, with the first nibble in bits 3:0. Reads drive the low nibble and then the high nibble on `pins[3:0]`, with `pins[15:4]` at 0. Each byte is popped once, on the first of its two reads.
- R7: Each queue returns bytes in the order they were written. `q_full[i]` is 1 when queue i holds 16 entries, and `q_empty[i]` is 1 when it holds none.
- R8: A chunk is written only when every queue it targets has a free entry. Otherwise it waits in the shifter. `pix_ready` is 1 only while the shifter holds at most 16 bits. No pixel bits are lost.
- R9: A read strobe that needs data from an empty queue pops nothing, leaves `pins` unchanged and sets `underflow`. The flag stays set until the block is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Synchronous run enable; low clears all state |
| panel_mode | input | 2 | 00: 4 pins, 01: 8 pins, 1x: 16 pins |
| pix_valid | input | 1 | Pixel offered |
| pix_data | input | 16 | Pixel value, low bits used |
| pix_bits | input | 5 | Pixel width, 1..16, 0 means 16 |
| pix_ready | output | 1 | Pixel accepted when high together with pix_valid |
| pclk_en | input | 1 | Pixel-clock read strobe |
| pins | output | 16 | Registered panel data |
| q_empty | output | 2 | Per-queue empty status |
| q_full | output | 2 | Per-queue full status |
| underflow | output | 1 | Sticky read-on-empty flag |

## Verification
The hardest condition to reach from the ports is back-pressure, where the shifter holds a complete chunk that cannot enter a full queue. The stimulus drives it by writing bytes with no reads until queue 0 is full and three more bytes sit in the shifter, which drops `pix_ready`. It then drains all nineteen bytes and checks their order, showing that the held chunk and the bits behind it each moved into the queue as space opened. Nibble mode also needs care, because each pop covers two reads. The bench watches `q_empty` between the reads to confirm that the second nibble does not consume a new byte.

// File: rtl/lpf_pkg.sv
package lpf_pkg;
  localparam int PIX_W = 16;

  typedef enum logic [1:0] {
    PM_NIB  = 2'b00,
    PM_BYTE = 2'b01,
    PM_WORD = 2'b10,
    PM_WALT = 2'b11
  } pmode_e;

  function automatic logic is_word(input logic [1:0] m);
    return m[1];
  endfunction

  // bits per chunk for a panel mode
  function automatic logic [4:0] chunk_bits(input logic [1:0] m);
    if (m[1]) return 5'd16;
    else if (m[0]) return 5'd8;
    else return 5'd4;
  endfunction

  // pixel width field: 0 stands for 16
  function automatic logic [4:0] eff_width(input logic [4:0] b);
    if (b == 5'd0 || b > 5'd16) return 5'd16;
    return b;
  endfunction

  function automatic logic [15:0] low_mask(input logic [4:0] n);
    if (n >= 5'd16) return 16'hFFFF;
    return (16'h1 << n) - 16'h1;
  endfunction
endpackage

// File: rtl/lpf_packer.sv
module lpf_packer
  import lpf_pkg::*;
#(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [1:0]       mode,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_data,
  input  logic [4:0]       pix_bits,
  input  logic             take,
  output logic             in_ready,
  output logic             chunk_rdy,
  output logic [15:0]      chunk
);
  localparam int CNT_W = $clog2(ACC_W + 1);
  localparam logic [CNT_W-1:0] READY_LIM = CNT_W'(ACC_W - PIX_W);

  logic [ACC_W-1:0] acc, acc_n, base, newbits;
  logic [CNT_W-1:0] fill, fill_n, base_fill, cs;
  logic [4:0]       w;
  logic             accept, emit;

  assign cs        = CNT_W'(chunk_bits(mode));
  assign w         = eff_width(pix_bits);
  assign chunk_rdy = !clr && (fill >= cs);
  assign chunk     = acc[15:0] & low_mask(cs[4:0]);
  assign in_ready  = !clr && (fill <= READY_LIM);
  assign accept    = pix_valid && in_ready;
  assign emit      = take && chunk_rdy;

  always_comb begin
    base      = emit ? (acc >> cs) : acc;
    base_fill = emit ? (fill - cs) : fill;
    newbits   = ACC_W'(pix_data & low_mask(w)) << base_fill;
    acc_n     = accept ? (base | newbits) : base;
    fill_n    = accept ? (base_fill + CNT_W'(w)) : base_fill;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc  <= '0;
      fill <= '0;
    end else if (clr) begin
      acc  <= '0;
      fill <= '0;
    end else begin
      acc  <= acc_n;
      fill <= fill_n;
    end
  end

  // R8: shifter never exceeds its storage
  assert_fill_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(ACC_W));
  // R3: a chunk that is not taken stays ready while the mode holds
  assert_chunk_held_R3: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (chunk_rdy && !take) |=> (chunk_rdy || clr || mode != $past(mode)));
endmodule

// File: rtl/lpf_byte_queue.sv
module lpf_byte_queue #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem   [DEPTH];
  logic [W-1:0]  mem_n [DEPTH];
  logic [CW-1:0] cnt, cnt_n;
  logic [IW-1:0] widx;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign dout    = mem[0];
  assign do_pop  = pop && !empty;
  assign do_push = push && !full;
  assign widx    = IW'(cnt - (do_pop ? CW'(1) : CW'(0)));

  always_comb begin
    for (int i = 0; i < DEPTH; i++) mem_n[i] = mem[i];
    if (do_pop) begin
      for (int i = 0; i < DEPTH - 1; i++) mem_n[i] = mem[i+1];
      mem_n[DEPTH-1] = '0;
    end
    if (do_push) mem_n[widx] = din;
    cnt_n = cnt + (do_push ? CW'(1) : CW'(0)) - (do_pop ? CW'(1) : CW'(0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (clr) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      cnt <= cnt_n;
      for (int i = 0; i < DEPTH; i++) mem[i] <= mem_n[i];
    end
  end

  // R8: the writer never offers a byte to a full queue
  assert_no_push_full_R8: assert property (@(posedge clk) disable iff (!rst_n || clr)
    push |-> !full);
  // R7: a lone pop removes exactly one entry
  assert_pop_count_R7: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (pop && !push && !empty) |=> (cnt == $past(cnt) - CW'(1)));
  // R9: the reader never pops an empty queue
  assert_no_pop_empty_R9: assert property (@(posedge clk) disable iff (!rst_n || clr)
    pop |-> !empty);
endmodule

// File: rtl/lpf_pin_drive.sv
module lpf_pin_drive
  import lpf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic [1:0]  mode,
  input  logic        rd,
  input  logic [7:0]  q0_dout,
  input  logic [7:0]  q1_dout,
  input  logic        q0_empty,
  input  logic        q1_empty,
  output logic        pop0,
  output logic        pop1,
  output logic [15:0] pins,
  output logic        underflow
);
  logic        phase;
  logic [3:0]  hi_nib;
  logic        ok, want0, want1, starve, serve;
  logic [15:0] nxt_pins;

  always_comb begin
    ok       = 1'b0;
    want0    = 1'b0;
    want1    = 1'b0;
    nxt_pins = pins;
    if (is_word(mode)) begin
      ok       = !q0_empty && !q1_empty;
      want0    = 1'b1;
      want1    = 1'b1;
      nxt_pins = {q1_dout, q0_dout};
    end else if (mode == PM_BYTE) begin
      ok       = !q0_empty;
      want0    = 1'b1;
      nxt_pins = {8'h00, q0_dout};
    end else if (!phase) begin
      ok       = !q0_empty;
      want0    = 1'b1;
      nxt_pins = {12'h000, q0_dout[3:0]};
    end else begin
      ok       = 1'b1;
      nxt_pins = {12'h000, hi_nib};
    end
  end

  assign serve  = rd && ok && !clr;
  assign starve = rd && !ok && !clr;
  assign pop0   = serve && want0;
  assign pop1   = serve && want1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins      <= '0;
      phase     <= 1'b0;
      hi_nib    <= '0;
      underflow <= 1'b0;
    end else if (clr) begin
      pins      <= '0;
      phase     <= 1'b0;
      hi_nib    <= '0;
      underflow <= 1'b0;
    end else begin
      if (serve) begin
        pins <= nxt_pins;
        if (mode == PM_NIB) begin
          phase <= !phase;
          if (!phase) hi_nib <= q0_dout[7:4];
        end
      end
      if (starve) underflow <= 1'b1;
    end
  end

  // R9: a starved read keeps the pins and raises the flag
  assert_hold_on_starve_R9: assert property (@(posedge clk) disable iff (!rst_n || clr)
    starve |=> ($stable(pins) && underflow));
  // R1: a disabled cycle leaves the pins at zero
  assert_pins_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pins == 16'h0 && !underflow));
endmodule

// File: rtl/lcd_pack_fifo.sv
module lcd_pack_fifo
  import lpf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int ACC_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic [1:0]  panel_mode,
  input  logic        pix_valid,
  input  logic [15:0] pix_data,
  input  logic [4:0]  pix_bits,
  output logic        pix_ready,
  input  logic        pclk_en,
  output logic [15:0] pins,
  output logic [1:0]  q_empty,
  output logic [1:0]  q_full,
  output logic        underflow
);
  localparam int NQ = 2;

  logic        clr, take, chunk_rdy;
  logic [15:0] chunk;
  logic        nib_have;
  logic [3:0]  nib_lo;
  logic [NQ-1:0] push_v, pop_v;
  logic [7:0]  din_v  [NQ];
  logic [7:0]  dout_v [NQ];

  assign clr = !enable;

  lpf_packer #(.ACC_W(ACC_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .clr(clr), .mode(panel_mode),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_bits(pix_bits),
    .take(take), .in_ready(pix_ready), .chunk_rdy(chunk_rdy), .chunk(chunk)
  );

  // write steering per panel mode
  always_comb begin
    take     = 1'b0;
    push_v   = '0;
    din_v[0] = chunk[7:0];
    din_v[1] = chunk[15:8];
    if (is_word(panel_mode)) begin
      take   = chunk_rdy && !q_full[0] && !q_full[1];
      push_v = {take, take};
    end else if (panel_mode == PM_BYTE) begin
      take      = chunk_rdy && !q_full[0];
      push_v[0] = take;
    end else begin
      take      = chunk_rdy && (!nib_have || !q_full[0]);
      push_v[0] = chunk_rdy && nib_have && !q_full[0];
      din_v[0]  = {chunk[3:0], nib_lo};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nib_have <= 1'b0;
      nib_lo   <= '0;
    end else if (clr) begin
      nib_have <= 1'b0;
      nib_lo   <= '0;
    end else if (panel_mode == PM_NIB && take) begin
      nib_have <= !nib_have;
      if (!nib_have) nib_lo <= chunk[3:0];
    end
  end

  for (genvar g = 0; g < NQ; g++) begin : g_q
    lpf_byte_queue #(.DEPTH(DEPTH), .W(8)) u_q (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .push(push_v[g]), .din(din_v[g]), .pop(pop_v[g]),
      .dout(dout_v[g]), .empty(q_empty[g]), .full(q_full[g])
    );
  end

  lpf_pin_drive u_drv (
    .clk(clk), .rst_n(rst_n), .clr(clr), .mode(panel_mode), .rd(pclk_en),
    .q0_dout(dout_v[0]), .q1_dout(dout_v[1]),
    .q0_empty(q_empty[0]), .q1_empty(q_empty[1]),
    .pop0(pop_v[0]), .pop1(pop_v[1]), .pins(pins), .underflow(underflow)
  );

  // R5: a paired write leaves both queues holding data
  assert_pair_write_R5: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (push_v[0] && push_v[1]) |=> (!q_empty[0] && !q_empty[1]));
  // R4: byte mode never writes queue 1
  assert_byte_q1_idle_R4: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (panel_mode == PM_BYTE) |-> !push_v[1]);
  // R1: disabled block refuses pixels
  assert_no_ready_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !pix_ready);
endmodule

// File: tb/sim_lcd_pack_fifo.sv
module sim_lcd_pack_fifo;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  panel_mode = 2'b01;
  logic        pix_valid = 1'b0;
  logic [15:0] pix_data = '0;
  logic [4:0]  pix_bits = '0;
  logic        pix_ready;
  logic        pclk_en = 1'b0;
  logic [15:0] pins;
  logic [1:0]  q_empty, q_full;
  logic        underflow;

  int n_checks = 0;
  int n_fail   = 0;
  logic [2047:0] sbits;
  int slen;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_pack_fifo u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .panel_mode(panel_mode),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_bits(pix_bits),
    .pix_ready(pix_ready), .pclk_en(pclk_en), .pins(pins),
    .q_empty(q_empty), .q_full(q_full), .underflow(underflow)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic restart(input logic [1:0] m);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    panel_mode = m;
    @(negedge clk);
    enable = 1'b1;
    sbits = '0;
    slen  = 0;
  endtask

  task automatic push_px(input logic [15:0] d, input logic [4:0] b);
    int w;
    w = (b == 5'd0) ? 16 : int'(b);
    @(negedge clk);
    while (!pix_ready) @(negedge clk);
    pix_valid = 1'b1;
    pix_data  = d;
    pix_bits  = b;
    for (int i = 0; i < w; i++) sbits[slen + i] = d[i];
    slen += w;
    @(negedge clk);
    pix_valid = 1'b0;
  endtask

  task automatic rd(output logic [15:0] v);
    @(negedge clk);
    pclk_en = 1'b1;
    @(negedge clk);
    pclk_en = 1'b0;
    v = pins;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(q_empty == 2'b11 && q_full == 2'b00, "R1 empty", {28'h0, q_full, q_empty}, 32'h3);
    chk(pins == 16'h0 && !underflow && !pix_ready, "R1 outputs", {pins, 15'h0, pix_ready}, 0);
  endtask

  task automatic t_byte_pack;
    logic [15:0] v;
    restart(2'b01);
    push_px(16'h0005, 5'd3); push_px(16'h0013, 5'd5); push_px(16'h005A, 5'd7);
    push_px(16'h0001, 5'd1); push_px(16'h0002, 5'd2); push_px(16'h002D, 5'd6);
    push_px(16'h000C, 5'd4); push_px(16'h0009, 5'd4);
    idle(3);
    chk(q_empty[1], "R4 q1 empty", {31'h0, q_empty[1]}, 1);
    for (int i = 0; i < 4; i++) begin
      rd(v);
      chk(v == {8'h00, sbits[8*i +: 8]}, "R2 R3 R4 byte order", v, {8'h00, sbits[8*i +: 8]});
    end
    chk(q_empty == 2'b11, "R7 drained", q_empty, 3);
  endtask

  task automatic t_word;
    logic [15:0] v;
    restart(2'b10);
    push_px(16'h0015, 5'd5); push_px(16'h0623, 5'd11);
    push_px(16'h0BEEF & 16'hFFFF, 5'd0);
    push_px(16'h01A5, 5'd9); push_px(16'h004B, 5'd7);
    idle(3);
    chk(q_empty == 2'b00, "R5 both filled", q_empty, 0);
    for (int i = 0; i < 3; i++) begin
      rd(v);
      chk(v == sbits[16*i +: 16], "R5 R2 word", v, sbits[16*i +: 16]);
    end
    chk(q_empty == 2'b11, "R5 both drained", q_empty, 3);
  endtask

  task automatic t_nibble;
    logic [15:0] v;
    restart(2'b00);
    push_px(16'h0006, 5'd3); push_px(16'h0003, 5'd3); push_px(16'h0002, 5'd2);
    push_px(16'h00C9, 5'd8);
    idle(3);
    rd(v);
    chk(v == {12'h0, sbits[3:0]}, "R6 nibble0", v, {12'h0, sbits[3:0]});
    rd(v);
    chk(v == {12'h0, sbits[7:4]}, "R6 nibble1", v, {12'h0, sbits[7:4]});
    chk(!q_empty[0], "R6 one pop per byte", {31'h0, q_empty[0]}, 0);
    rd(v);
    chk(v == {12'h0, sbits[11:8]}, "R6 nibble2", v, {12'h0, sbits[11:8]});
    chk(q_empty[0], "R6 second byte popped", {31'h0, q_empty[0]}, 1);
    rd(v);
    chk(v == {12'h0, sbits[15:12]}, "R6 nibble3", v, {12'h0, sbits[15:12]});
  endtask

  task automatic t_full;
    logic [15:0] v;
    restart(2'b01);
    for (int i = 0; i < 19; i++) push_px(16'(8'h30 + i), 5'd8);
    idle(3);
    chk(q_full[0], "R7 full flag", {31'h0, q_full[0]}, 1);
    chk(!pix_ready, "R8 ready low", {31'h0, pix_ready}, 0);
    for (int i = 0; i < 19; i++) begin
      rd(v);
      chk(v == 16'(8'h30 + i), "R8 R7 no loss", v, 16'(8'h30 + i));
    end
    chk(!underflow, "R9 no false flag", {31'h0, underflow}, 0);
  endtask

  task automatic t_under;
    logic [15:0] v, last;
    restart(2'b01);
    push_px(16'h00E1, 5'd8);
    idle(3);
    rd(last);
    rd(v);
    chk(underflow, "R9 flag", {31'h0, underflow}, 1);
    chk(v == last, "R9 pins hold", v, last);
    idle(2);
    chk(underflow, "R9 sticky", {31'h0, underflow}, 1);
    push_px(16'h00AB, 5'd8);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(pins == 16'h0 && !underflow, "R1 disable clears", {pins, 15'h0, underflow}, 0);
    chk(q_empty == 2'b11 && !pix_ready, "R1 disable empties", {30'h0, q_empty}, 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_byte_pack();
    t_word();
    t_nibble();
    t_full();
    t_under();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule